// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits behind a serial-bus front end of a byte-addressed nonvolatile memory model. The front end decodes a write command and hands over three kinds of event: a start address, a stream of data bytes, and the stop of the transfer. Data bytes are staged in a page buffer that holds one page of 64 bytes. A per-offset valid mask records which page slots were filled. The block keeps the internal address pointer. That pointer advances only inside the current page, so an overlong burst wraps round and overwrites its own earlier bytes.

At stop, the write-protect pin is sampled once. If protection is off and at least one byte was staged, a write cycle starts. The busy flag stays high for a parameterized number of clock cycles. At the edge where busy falls, all staged bytes are written into the array in one step. The array is a register file with a plain combinational read port. A protected stop, or a stop with no staged data, discards the staged bytes and starts no write cycle. While busy is high, every incoming event is ignored.

Top module: `eepw_page_writer`

## Requirements
- R1: After reset, busy is 0, the pointer is 0, and every array byte reads 8'hFF.
- R2: An address load accepted while idle sets the pointer to cmd_addr and empties the staged page.
- R3: Each accepted data byte is staged at the page offset given by the low 6 pointer bits. Only those 6 bits then increment, wrapping from 63 to 0, and the upper pointer bits stay unchanged.
- R4: When more than 64 bytes arrive before stop, a byte landing on an already filled offset replaces it, and only the last value is written.
- R5: A stop with staged data and wp low raises busy on the next cycle. Busy stays high for exactly WRITE_CYCLES cycles. The array keeps its old contents until the edge on which busy falls, and the new data is readable from that edge on.
- R6: A commit writes only the offsets that were received, into the page selected by the upper pointer bits. Every other array byte keeps its value.
- R7: A stop with wp high writes nothing, keeps busy low, and discards the staged bytes, so a later stop commits nothing.
- R8: wp is looked at only in the stop cycle. Changing it while busy does not alter the commit.
- R9: A stop with no staged bytes (address only) keeps busy low.
- R10: While busy, address loads, data bytes and stops are ignored. The pointer does not move, and none of these inputs reach the array or the next command.
- R11: After a single byte written at address A, the pointer reads A with its low 6 bits incremented, and it keeps that value after the commit.
- R12: When several events arrive in one idle cycle, stop wins over address load, and address load wins over data byte. The losing events are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load cmd_addr into the pointer and start a new command |
| cmd_addr | input | ADDR_W | Start address of the write command |
| byte_valid | input | 1 | A data byte is presented on byte_data |
| byte_data | input | 8 | Data byte to stage |
| stop_evt | input | 1 | End of the bus transfer |
| wp | input | 1 | Write protect; high blocks the whole array, sampled at stop |
| busy | output | 1 | Internal write cycle in progress |
| cur_ptr | output | ADDR_W | Internal address pointer |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array contents at rd_addr (combinational) |

## Verification
A wrong pointer shows on cur_ptr one cycle after the byte or load that caused it. It also shows as bytes placed at shifted or wrapped addresses once the next commit lands. A corrupted valid mask or stale page buffer appears only when busy falls: slots that were never sent are overwritten, or sent bytes are missing, somewhere in the committed page. A mis-sampled protect pin or a wrong empty-page decision shows one cycle after stop, as a busy flag that is wrong. A miscounted timer shows as busy falling at the wrong cycle, with the array changing at that same edge.

// File: rtl/eepw_pkg.sv
`timescale 1ns/1ps
package eepw_pkg;

  // What the controller does with the inputs of one cycle.
  typedef enum logic [2:0] {
    EV_IDLE   = 3'd0,
    EV_LOAD   = 3'd1,
    EV_BYTE   = 3'd2,
    EV_COMMIT = 3'd3,
    EV_DROP   = 3'd4,
    EV_HELD   = 3'd5
  } ev_e;

  // Priority: busy blocks all, then stop, then address load, then data byte.
  function automatic ev_e classify(logic busy, logic stop, logic load,
                                   logic byte_in, logic wp, logic any_staged);
    ev_e ev;
    if (busy)
      ev = (stop || load || byte_in) ? EV_HELD : EV_IDLE;
    else if (stop)
      ev = (!wp && any_staged) ? EV_COMMIT : EV_DROP;
    else if (load)
      ev = EV_LOAD;
    else if (byte_in)
      ev = EV_BYTE;
    else
      ev = EV_IDLE;
    return ev;
  endfunction

  // Increment only the low pw bits of a pointer; upper bits are kept.
  function automatic logic [31:0] page_step(logic [31:0] p, int unsigned pw);
    logic [31:0] low_mask;
    low_mask = (32'd1 << pw) - 32'd1;
    return (p & ~low_mask) | ((p + 32'd1) & low_mask);
  endfunction

endpackage

// File: rtl/eepw_addr_ctr.sv
`timescale 1ns/1ps
module eepw_addr_ctr #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_en,
  output logic [ADDR_W-1:0] ptr
);
  import eepw_pkg::*;

  logic [ADDR_W-1:0] ptr_next;
  assign ptr_next = ADDR_W'(page_step(32'(ptr), PAGE_W));

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (load_en)
      ptr <= load_val;
    else if (step_en)
      ptr <= ptr_next;
  end
endmodule

// File: rtl/eepw_page_buf.sv
`timescale 1ns/1ps
module eepw_page_buf #(
  parameter int PAGE_W = 6,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       wr_en,
  input  logic [PAGE_W-1:0]          wr_off,
  input  logic [7:0]                 wr_data,
  output logic [PAGE_BYTES-1:0][7:0] stage_data,
  output logic [PAGE_BYTES-1:0]      stage_mask
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_data <= '0;
      stage_mask <= '0;
    end else if (clear) begin
      stage_mask <= '0;
    end else if (wr_en) begin
      stage_data[wr_off] <= wr_data;
      stage_mask[wr_off] <= 1'b1;
    end
  end
endmodule

// File: rtl/eepw_wtimer.sv
`timescale 1ns/1ps
module eepw_wtimer #(
  parameter int WRITE_CYCLES = 40,
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fire
);
  logic [CNT_W-1:0] remain;

  assign fire = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= CNT_W'(WRITE_CYCLES - 1);
    end else if (busy) begin
      if (remain == '0)
        busy <= 1'b0;
      else
        remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/eepw_array.sv
`timescale 1ns/1ps
module eepw_array #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 6,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int SEL_W = ADDR_W - PAGE_W,
  localparam int PAGE_CNT = 1 << SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  logic [SEL_W-1:0]           page_sel,
  input  logic [PAGE_BYTES-1:0][7:0] stage_data,
  input  logic [PAGE_BYTES-1:0]      stage_mask,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [7:0]                 rd_data
);
  logic [7:0] cells [PAGE_CNT][PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGE_CNT; p++)
        for (int i = 0; i < PAGE_BYTES; i++)
          cells[p][i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (stage_mask[i])
          cells[page_sel][i] <= stage_data[i];
    end
  end

  assign rd_data = cells[rd_addr[ADDR_W-1:PAGE_W]][rd_addr[PAGE_W-1:0]];
endmodule

// File: rtl/eepw_page_writer.sv
`timescale 1ns/1ps
module eepw_page_writer #(
  parameter int ADDR_W       = 9,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              stop_evt,
  input  logic              wp,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_ptr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  import eepw_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int SEL_W      = ADDR_W - PAGE_W;

  logic [PAGE_BYTES-1:0][7:0] stage_data;
  logic [PAGE_BYTES-1:0]      stage_mask;
  logic                       any_staged;
  ev_e                        ev;

  // Named internal events, also observed by the checker.
  logic accept_addr;
  logic accept_byte;
  logic stop_commit;
  logic stop_drop;
  logic commit_fire;
  logic stage_clear;

  assign any_staged  = |stage_mask;
  assign ev          = classify(busy, stop_evt, addr_load, byte_valid, wp, any_staged);
  assign accept_addr = (ev == EV_LOAD);
  assign accept_byte = (ev == EV_BYTE);
  assign stop_commit = (ev == EV_COMMIT);
  assign stop_drop   = (ev == EV_DROP);
  assign stage_clear = accept_addr || stop_drop || commit_fire;

  eepw_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (accept_addr),
    .load_val (cmd_addr),
    .step_en  (accept_byte),
    .ptr      (cur_ptr)
  );

  eepw_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (stage_clear),
    .wr_en      (accept_byte),
    .wr_off     (cur_ptr[PAGE_W-1:0]),
    .wr_data    (byte_data),
    .stage_data (stage_data),
    .stage_mask (stage_mask)
  );

  eepw_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (stop_commit),
    .busy  (busy),
    .fire  (commit_fire)
  );

  eepw_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit_fire),
    .page_sel   (cur_ptr[ADDR_W-1:ADDR_W-SEL_W]),
    .stage_data (stage_data),
    .stage_mask (stage_mask),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/eepw_page_writer_chk.sv
`timescale 1ns/1ps
module eepw_page_writer_chk #(
  parameter int ADDR_W       = 9,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [ADDR_W-1:0] cur_ptr,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              accept_addr,
  input logic              accept_byte,
  input logic              stop_commit,
  input logic              stop_drop,
  input logic              commit_fire
);
  logic [31:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)
      busy_run <= '0;
    else if (busy)
      busy_run <= busy_run + 32'd1;
    else
      busy_run <= '0;
  end

  // R5
  commit_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_commit |=> busy);

  // R5
  busy_ends_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit_fire));

  // R5
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 32'(WRITE_CYCLES));

  // R7
  drop_keeps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_drop |=> !busy);

  // R3
  ptr_page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_byte |=> (cur_ptr[ADDR_W-1:PAGE_W] == $past(cur_ptr[ADDR_W-1:PAGE_W])) &&
                    (cur_ptr[PAGE_W-1:0] == PAGE_W'($past(cur_ptr[PAGE_W-1:0]) + 1'b1)));

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_addr |=> cur_ptr == $past(cmd_addr));

  // R10
  busy_freezes_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_ptr));
endmodule

bind eepw_page_writer eepw_page_writer_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .cur_ptr     (cur_ptr),
  .cmd_addr    (cmd_addr),
  .accept_addr (accept_addr),
  .accept_byte (accept_byte),
  .stop_commit (stop_commit),
  .stop_drop   (stop_drop),
  .commit_fire (commit_fire)
);

// File: tb/test_eepw_page_writer.sv
`timescale 1ns/1ps
module test_eepw_page_writer;
  localparam int AW = 8;
  localparam int PW = 6;
  localparam int WC = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_load = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_data = '0;
  logic          stop_evt = 1'b0;
  logic          wp = 1'b0;
  logic          busy;
  logic [AW-1:0] cur_ptr;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of the requirements
  logic [7:0]  mdl [DEPTH];
  logic [7:0]  m_buf [64];
  logic [63:0] m_mask = '0;
  logic [7:0]  m_ptr = '0;
  logic [1:0]  m_page = '0;
  bit          m_busy = 1'b0;

  always #2.5 clk = ~clk;

  eepw_page_writer #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WC)) i_eepw_page_writer (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .cmd_addr(cmd_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp),
    .busy(busy), .cur_ptr(cur_ptr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; the model follows the priority rules (R12).
  task automatic cyc(input bit ld, input logic [7:0] a, input bit bv,
                     input logic [7:0] d, input bit st, input bit w, input string tag);
    addr_load = ld; cmd_addr = a; byte_valid = bv; byte_data = d;
    stop_evt = st; wp = w;
    @(negedge clk);
    addr_load = 1'b0; byte_valid = 1'b0; stop_evt = 1'b0;
    if (!m_busy) begin
      if (st) begin
        if (!w && m_mask != 0) begin
          m_busy = 1'b1;
          m_page = m_ptr[7:6];
        end else begin
          m_mask = '0;
        end
      end else if (ld) begin
        m_ptr = a;
        m_mask = '0;
      end else if (bv) begin
        m_buf[m_ptr[5:0]] = d;
        m_mask[m_ptr[5:0]] = 1'b1;
        m_ptr = {m_ptr[7:6], m_ptr[5:0] + 6'd1};
      end
    end
    chk(busy == m_busy, {tag, " busy"}, 32'(busy), 32'(m_busy));
    chk(cur_ptr == m_ptr, {tag, " ptr"}, 32'(cur_ptr), 32'(m_ptr));
  endtask

  task automatic sweep(input string tag);
    int bad = 0;
    int first = -1;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #0.1;
      if (rd_data !== mdl[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    if (first < 0)
      chk(1'b1, tag, 0, 0);
    else
      chk(1'b0, {tag, " array"}, {16'(first), 8'h0, rd_data}, {16'(first), 8'h0, mdl[first]});
  endtask

  // Counts busy cycles, checks R5 timing and hold-off, then applies the commit.
  task automatic wait_commit(input int already, input string tag);
    int n = already;
    logic [7:0] probe = '0;
    for (int i = 63; i >= 0; i--)
      if (m_mask[i]) probe = {m_page, 6'(i)};
    rd_addr = probe;
    #0.1;
    // R5: old contents still visible during the write cycle
    chk(rd_data == mdl[probe], {tag, " R5 hold"}, 32'(rd_data), 32'(mdl[probe]));
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == WC, {tag, " R5 busy length"}, n, WC);
    for (int i = 0; i < 64; i++)
      if (m_mask[i]) mdl[{m_page, 6'(i)}] = m_buf[i];
    m_mask = '0;
    m_busy = 1'b0;
    sweep({tag, " R6 contents"});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) mdl[a] = 8'hFF;
    for (int i = 0; i < 64; i++) m_buf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(cur_ptr == 0, "R1 ptr", 32'(cur_ptr), 0);
    sweep("R1 erased");

    // R2 R11 single byte write
    cyc(1, 8'h05, 0, 0, 0, 0, "R2 load");
    cyc(0, 0, 1, 8'hA5, 0, 0, "R11 byte");
    chk(cur_ptr == 8'h06, "R11 next ptr", 32'(cur_ptr), 32'h06);
    cyc(0, 0, 0, 0, 1, 0, "R5 stop");
    wait_commit(0, "R11");
    chk(cur_ptr == 8'h06, "R11 ptr after commit", 32'(cur_ptr), 32'h06);

    // R3 R4 overlong page write, R8 wp toggled while busy
    cyc(1, 8'h47, 0, 0, 0, 0, "R2 load page1");
    for (int k = 0; k < 70; k++) begin
      cyc(0, 0, 1, 8'(k * 3 + 1), 0, 0, "R3 burst");
      chk(cur_ptr == {2'b01, 6'((7 + k + 1) % 64)}, "R3 wrap ptr",
          32'(cur_ptr), 32'({2'b01, 6'((7 + k + 1) % 64)}));
    end
    cyc(0, 0, 0, 0, 1, 0, "R5 stop page1");
    cyc(0, 0, 0, 0, 0, 1, "R8 wp high while busy");
    wait_commit(1, "R8");
    rd_addr = 8'h47;
    #0.1;
    chk(rd_data == 8'hC1, "R4 overwritten slot", 32'(rd_data), 32'hC1);
    wp = 1'b0;

    // R3 R6 partial page across the wrap
    cyc(1, 8'hBE, 0, 0, 0, 0, "R2 load page2");
    for (int k = 0; k < 4; k++)
      cyc(0, 0, 1, 8'(8'h50 + k), 0, 0, "R3 wrap bytes");
    chk(cur_ptr == 8'h82, "R3 upper bits kept", 32'(cur_ptr), 32'h82);
    cyc(0, 0, 0, 0, 1, 0, "R5 stop page2");
    wait_commit(0, "R6");

    // R7 protected stop discards staged bytes
    cyc(1, 8'hC0, 0, 0, 0, 0, "R2 load page3");
    for (int k = 0; k < 3; k++)
      cyc(0, 0, 1, 8'(8'h70 + k), 0, 0, "R7 stage");
    cyc(0, 0, 0, 0, 1, 1, "R7 protected stop");
    cyc(0, 0, 0, 0, 1, 0, "R7 later stop");
    sweep("R7 untouched");

    // R9 address-only stop
    cyc(1, 8'h10, 0, 0, 0, 0, "R9 load");
    cyc(0, 0, 0, 0, 1, 0, "R9 empty stop");

    // R10 inputs ignored while busy
    cyc(1, 8'h20, 0, 0, 0, 0, "R10 load");
    cyc(0, 0, 1, 8'h3C, 0, 0, "R10 byte");
    cyc(0, 0, 0, 0, 1, 0, "R10 stop");
    cyc(0, 0, 1, 8'h99, 0, 0, "R10 byte busy");
    cyc(1, 8'h90, 0, 0, 0, 0, "R10 load busy");
    cyc(0, 0, 0, 0, 1, 0, "R10 stop busy");
    wait_commit(3, "R10");
    cyc(0, 0, 0, 0, 1, 0, "R10 nothing carried");
    sweep("R10 contents");

    // R12 same-cycle priority
    cyc(1, 8'h30, 1, 8'hEE, 0, 0, "R12 load beats byte");
    cyc(0, 0, 1, 8'hDD, 1, 0, "R12 stop beats byte");
    cyc(0, 0, 1, 8'h61, 0, 0, "R12 stage");
    cyc(1, 8'h60, 0, 0, 1, 0, "R12 stop beats load");
    wait_commit(0, "R12");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule